// File: doc/BRIEF.md
# Parallel ADC Scan Sequencer

This block is the host-side controller for an eight-input, 12-bit converter that has a parallel result bus. The converter is driven through active-low select, write and read strobes, a three-bit channel address, a BUSY status line and a clock input. The block divides the system clock down to make the converter clock. It walks the enabled channels in rising order and wraps around. For each channel it issues a start strobe that also carries the channel address. It then waits for BUSY to return high and reads the 12-bit word back. The word goes into a result register for that channel, with a valid bit.

Software sets up the scan through plain control pins. These are a run enable, a channel mask, the converter clock half-period and the length of the read pulse. The stored results are read by putting a channel number on `res_sel`, which shows that channel's word and valid bit. A one-cycle `res_rd` pulse consumes the entry. A conversion whose BUSY never comes back high raises a sticky timeout flag, and the scan moves on to the next channel.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, `adc_cs_n`, `adc_wr_n` and `adc_rd_n` are high, every channel's valid bit is 0 and `timeout_err` is 0.
- R2: `adc_clk` is high for `clk_div`+1 system clocks and low for `clk_div`+1 system clocks, so its period is 2·(`clk_div`+1) cycles. `clk_div` must be at least 1.
- R3: A start strobe holds `adc_cs_n` and `adc_wr_n` low together for exactly one cycle. During that cycle `adc_addr` carries the channel in plain binary (0 selects input 0, 7 selects input 7). The strobe falls only while `adc_clk` is high, one system clock after its rising edge.
- R4: Channels whose bit in `chan_mask` is 1 (bit n is channel n) are converted in ascending order and wrap from the highest back to the lowest. After reset the first channel is the lowest enabled one. Disabled channels get no strobe.
- R5: `adc_rd_n` goes low only after BUSY has gone low and then returned high following the start strobe. It is never low while BUSY is low, and never low unless `adc_cs_n` is low.
- R6: `adc_rd_n` stays low for `rd_hold` system clocks, or 1 clock when `rd_hold` is 0. The bus is sampled on the last of those clocks. `adc_cs_n` rises one clock after `adc_rd_n` rises.
- R7: The sampled word is stored in that channel's register and its valid bit is set, so `res_data`/`res_valid` show it when `res_sel` selects it. A `res_rd` pulse clears the selected channel's valid bit and leaves the other channels' valid bits as they were.
- R8: If BUSY has not returned high within 32 converter clock rising edges after a start strobe, `timeout_err` is set and stays set until reset. No read strobe is issued for that conversion, and the scan proceeds to the next enabled channel.
- R9: Two consecutive start strobes are at least `SETTLE_CYC` system clocks apart. The default of 63 is about 500 ns at 125 MHz and covers input multiplexer settling.
- R10: No start strobe is issued while `scan_en` is 0 or `chan_mask` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_en | input | 1 | Allows new conversions to start |
| chan_mask | input | NCH | Channel enable mask, bit n = channel n |
| clk_div | input | DIV_W | Converter clock half-period minus one, in system clocks |
| rd_hold | input | RDH_W | Read pulse length in system clocks |
| adc_clk | output | 1 | Converter clock |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_wr_n | output | 1 | Conversion start, active low |
| adc_rd_n | output | 1 | Result read, active low |
| adc_addr | output | CHW | Channel address for the start strobe |
| adc_busy | input | 1 | Converter busy, low while converting |
| adc_data | input | DW | Converter result bus |
| res_sel | input | CHW | Channel whose result is shown |
| res_rd | input | 1 | Consume pulse for the selected result |
| res_data | output | DW | Stored result of the selected channel |
| res_valid | output | 1 | Valid bit of the selected channel |
| timeout_err | output | 1 | Sticky conversion timeout flag |

## Verification
The scan is exercised with a full mask, which must produce the exact order 0 through 7 and then wrap. It is also run with a sparse mask of 0xA5, which shows whether disabled channels are truly skipped rather than given a slot. The converter model returns a different word for each channel, so a swapped address or capture lands on a mismatching result. A longer read pulse separates a correct hold count from a fixed one. A converter that never ends its conversion tells the timeout path apart from a read that waits forever. Runs with an empty mask and with the enable low check that no strobe leaks out.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_STRB,
    ST_WAIT,
    ST_READ,
    ST_REL
  } seq_state_e;
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_div,
  output logic             conv_clk,
  output logic             rise_q
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap = (cnt >= half_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      conv_clk <= 1'b0;
      rise_q   <= 1'b0;
    end else begin
      cnt      <= wrap ? '0 : cnt + 1'b1;
      if (wrap) conv_clk <= ~conv_clk;
      rise_q   <= wrap && !conv_clk;
    end
  end

  // the rise marker follows a real low-to-high step of the converter clock
  p_rise_marks_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |-> conv_clk && !$past(conv_clk));
endmodule

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
  parameter int NCH = 8,
  parameter int CHW = $clog2(NCH)
) (
  input  logic [CHW-1:0] cur,
  input  logic [NCH-1:0] mask,
  output logic [CHW-1:0] nxt,
  output logic           any
);
  always_comb begin
    int idx;
    nxt = '0;
    any = 1'b0;
    for (int k = 1; k <= NCH; k++) begin
      idx = (int'(cur) + k) % NCH;
      if (!any && mask[idx]) begin
        any = 1'b1;
        nxt = CHW'(idx);
      end
    end
  end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NCH = 8,
  parameter int DW  = 12,
  parameter int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cap_en,
  input  logic [CHW-1:0] cap_ch,
  input  logic [DW-1:0]  cap_data,
  input  logic [CHW-1:0] rd_sel,
  input  logic           rd_stb,
  output logic [DW-1:0]  rd_data,
  output logic           rd_valid
);
  logic [DW-1:0]  dat [NCH];
  logic [NCH-1:0] vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < NCH; i++) dat[i] <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (cap_en && cap_ch == CHW'(i)) begin
          dat[i] <= cap_data;
          vld[i] <= 1'b1;
        end else if (rd_stb && rd_sel == CHW'(i)) begin
          vld[i] <= 1'b0;
        end
      end
    end
  end

  assign rd_data  = dat[rd_sel];
  assign rd_valid = vld[rd_sel];

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    p_consume_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && rd_sel == CHW'(g) && !(cap_en && cap_ch == CHW'(g))) |=> !vld[g]);
    p_capture_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_en && cap_ch == CHW'(g)) |=> vld[g]);
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NCH        = 8,
  parameter int DW         = 12,
  parameter int DIV_W      = 8,
  parameter int RDH_W      = 4,
  parameter int SETTLE_CYC = 63,
  parameter int TMO_CLKS   = 32,
  localparam int CHW       = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_en,
  input  logic [NCH-1:0]   chan_mask,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [RDH_W-1:0] rd_hold,
  output logic             adc_clk,
  output logic             adc_cs_n,
  output logic             adc_wr_n,
  output logic             adc_rd_n,
  output logic [CHW-1:0]   adc_addr,
  input  logic             adc_busy,
  input  logic [DW-1:0]    adc_data,
  input  logic [CHW-1:0]   res_sel,
  input  logic             res_rd,
  output logic [DW-1:0]    res_data,
  output logic             res_valid,
  output logic             timeout_err
);
  localparam int GAP_W = $clog2(SETTLE_CYC + 1);
  localparam int TMO_W = $clog2(TMO_CLKS + 1);

  seq_state_e       state;
  logic [CHW-1:0]   tgt;
  logic [CHW-1:0]   nxt_ch;
  logic             any_en;
  logic             rise_q;
  logic             seen_low;
  logic [GAP_W-1:0] gap_cnt;
  logic [TMO_W-1:0] tmo_cnt;
  logic [RDH_W-1:0] hold_cnt;
  logic [RDH_W-1:0] eff_hold;
  logic             gap_ok;
  logic             cap_en;

  adc_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .half_div(clk_div),
    .conv_clk(adc_clk), .rise_q(rise_q)
  );

  adc_chan_pick #(.NCH(NCH), .CHW(CHW)) u_pick (
    .cur(tgt), .mask(chan_mask), .nxt(nxt_ch), .any(any_en)
  );

  assign eff_hold = (rd_hold == '0) ? RDH_W'(1) : rd_hold;
  assign gap_ok   = (gap_cnt >= GAP_W'(SETTLE_CYC));
  assign cap_en   = (state == ST_READ) && (hold_cnt == eff_hold - 1'b1);

  adc_result_bank #(.NCH(NCH), .DW(DW), .CHW(CHW)) u_bank (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_ch(tgt),
    .cap_data(adc_data), .rd_sel(res_sel), .rd_stb(res_rd),
    .rd_data(res_data), .rd_valid(res_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      tgt         <= CHW'(NCH - 1);
      adc_cs_n    <= 1'b1;
      adc_wr_n    <= 1'b1;
      adc_rd_n    <= 1'b1;
      adc_addr    <= '0;
      seen_low    <= 1'b0;
      gap_cnt     <= GAP_W'(SETTLE_CYC);
      tmo_cnt     <= '0;
      hold_cnt    <= '0;
      timeout_err <= 1'b0;
    end else begin
      if (!gap_ok) gap_cnt <= gap_cnt + 1'b1;
      case (state)
        ST_IDLE: begin
          if (scan_en && any_en) begin
            tgt   <= nxt_ch;
            state <= ST_ARM;
          end
        end
        ST_ARM: begin
          if (rise_q && gap_ok) begin
            adc_cs_n <= 1'b0;
            adc_wr_n <= 1'b0;
            adc_addr <= tgt;
            gap_cnt  <= '0;
            state    <= ST_STRB;
          end
        end
        ST_STRB: begin
          adc_cs_n <= 1'b1;
          adc_wr_n <= 1'b1;
          seen_low <= 1'b0;
          tmo_cnt  <= '0;
          state    <= ST_WAIT;
        end
        ST_WAIT: begin
          if (!adc_busy) seen_low <= 1'b1;
          if (adc_busy && seen_low) begin
            adc_cs_n <= 1'b0;
            adc_rd_n <= 1'b0;
            hold_cnt <= '0;
            state    <= ST_READ;
          end else if (rise_q) begin
            if (tmo_cnt == TMO_W'(TMO_CLKS - 1)) begin
              timeout_err <= 1'b1;
              state       <= ST_IDLE;
            end else begin
              tmo_cnt <= tmo_cnt + 1'b1;
            end
          end
        end
        ST_READ: begin
          if (cap_en) begin
            adc_rd_n <= 1'b1;
            state    <= ST_REL;
          end else begin
            hold_cnt <= hold_cnt + 1'b1;
          end
        end
        ST_REL: begin
          adc_cs_n <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // guards on the strobe protocol
  p_rd_inside_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_rd_n |-> !adc_cs_n);
  p_rd_not_while_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_rd_n |-> adc_busy);
  p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_wr_n |=> adc_wr_n);
  p_start_in_high_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_wr_n) |-> adc_clk && !adc_cs_n);
  p_cs_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_rd_n) |-> !adc_cs_n ##1 adc_cs_n);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> timeout_err);
  p_no_start_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !(scan_en && any_en)) |=> adc_wr_n);
endmodule

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;
  localparam int NCH = 8;
  localparam int DW  = 12;
  localparam int SETTLE = 63;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan_en = 1'b0;
  logic [NCH-1:0] chan_mask = '0;
  logic [7:0] clk_div = 8'd1;
  logic [3:0] rd_hold = 4'd1;
  logic adc_clk, adc_cs_n, adc_wr_n, adc_rd_n;
  logic [2:0] adc_addr;
  logic m_busy = 1'b1;
  logic [DW-1:0] m_data = '0;
  logic [2:0] res_sel = '0;
  logic res_rd = 1'b0;
  logic [DW-1:0] res_data;
  logic res_valid, timeout_err;

  int n_tests = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  adc_scan_seq i_adc_scan_seq (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .chan_mask(chan_mask),
    .clk_div(clk_div), .rd_hold(rd_hold), .adc_clk(adc_clk),
    .adc_cs_n(adc_cs_n), .adc_wr_n(adc_wr_n), .adc_rd_n(adc_rd_n),
    .adc_addr(adc_addr), .adc_busy(m_busy), .adc_data(m_data),
    .res_sel(res_sel), .res_rd(res_rd), .res_data(res_data),
    .res_valid(res_valid), .timeout_err(timeout_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] fval(input int ch);
    return 12'h0F0 + 12'(ch) * 12'h123;
  endfunction

  function automatic int next_en(input int cur, input logic [NCH-1:0] m);
    for (int k = 1; k <= NCH; k++)
      if (m[(cur + k) % NCH]) return (cur + k) % NCH;
    return -1;
  endfunction

  // behavioural converter
  bit   m_hang = 1'b0;
  bit   m_conv = 1'b0;
  int   m_edges = 0;
  int   m_ch = 0;
  logic m_clk_q = 1'b0;
  always @(posedge clk) begin
    m_clk_q <= adc_clk;
    if (!adc_cs_n && !adc_wr_n) begin
      m_ch    <= int'(adc_addr);
      m_conv  <= 1'b1;
      m_edges <= 0;
      m_busy  <= 1'b0;
    end else if (m_conv && adc_clk && !m_clk_q) begin
      m_edges <= m_edges + 1;
      if (m_edges >= 12 && !m_hang) begin
        m_busy <= 1'b1;
        m_conv <= 1'b0;
        m_data <= fval(m_ch);
      end
    end
  end

  // strobe monitors
  int cyc = 0;
  int log_ch [0:255];
  int log_n = 0;
  int last_start = -1;
  int rd_run = 0;
  int last_rd_len = 0;
  int rd_cnt = 0;
  bit rel_chk = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!adc_cs_n && !adc_wr_n) begin
        if (last_start >= 0)
          chk(cyc - last_start >= SETTLE, "R9 start spacing", cyc - last_start, SETTLE);
        chk(adc_clk == 1'b1, "R3 strobe in clock high phase", int'(adc_clk), 1);
        last_start = cyc;
        if (log_n < 256) log_ch[log_n] = int'(adc_addr);
        log_n++;
      end
      if (rel_chk) begin
        chk(adc_cs_n == 1'b1, "R6 select released after read", int'(adc_cs_n), 1);
        rel_chk = 1'b0;
      end
      if (!adc_rd_n) begin
        rd_run++;
        if (!m_busy) chk(1'b0, "R5 read during conversion", 0, 1);
      end else if (rd_run > 0) begin
        last_rd_len = rd_run;
        rd_cnt++;
        chk(adc_cs_n == 1'b0, "R6 select held one cycle past read", int'(adc_cs_n), 0);
        chk(rd_run == ((rd_hold == 0) ? 1 : int'(rd_hold)), "R6 read length", rd_run, int'(rd_hold));
        rd_run = 0;
        rel_chk = 1'b1;
      end
    end
  end

  task automatic wait_rise(output int cycles);
    logic prev;
    cycles = 0;
    prev = adc_clk;
    forever begin
      @(negedge clk);
      cycles++;
      if (adc_clk && !prev) break;
      prev = adc_clk;
    end
  endtask

  task automatic consume(input int ch);
    @(negedge clk);
    res_sel = 3'(ch);
    res_rd = 1'b1;
    @(negedge clk);
    res_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk(adc_cs_n && adc_wr_n && adc_rd_n, "R1 strobes idle", int'({adc_cs_n, adc_wr_n, adc_rd_n}), 7);
    chk(timeout_err == 1'b0, "R1 timeout clear", int'(timeout_err), 0);
    for (int c = 0; c < NCH; c++) begin
      res_sel = 3'(c);
      @(negedge clk);
      chk(res_valid == 1'b0, "R1 valid clear", int'(res_valid), 0);
    end
  endtask

  task automatic t_clkdiv(input int div);
    int p;
    clk_div = 8'(div);
    wait_rise(p);
    wait_rise(p);
    wait_rise(p);
    chk(p == 2 * (div + 1), "R2 converter clock period", p, 2 * (div + 1));
  endtask

  task automatic t_scan_full();
    int base;
    int guard;
    base = log_n;
    chan_mask = 8'hFF;
    scan_en = 1'b1;
    guard = 0;
    while (log_n < base + 10 && guard < 5000) begin @(negedge clk); guard++; end
    scan_en = 1'b0;
    repeat (200) @(negedge clk);
    for (int i = 0; i < 10; i++)
      chk(log_ch[base + i] == i % NCH, "R4 full-mask order / R3 address", log_ch[base + i], i % NCH);
    for (int c = 0; c < NCH; c++) begin
      res_sel = 3'(c);
      @(negedge clk);
      chk(res_valid == 1'b1, "R7 valid after capture", int'(res_valid), 1);
      chk(res_data == fval(c), "R7 stored word", int'(res_data), int'(fval(c)));
    end
  endtask

  task automatic t_consume();
    consume(3);
    res_sel = 3'd3;
    @(negedge clk);
    chk(res_valid == 1'b0, "R7 consume clears", int'(res_valid), 1'b0);
    res_sel = 3'd4;
    @(negedge clk);
    chk(res_valid == 1'b1, "R7 other channel kept", int'(res_valid), 1);
  endtask

  task automatic t_scan_sparse();
    int base;
    int guard;
    logic [NCH-1:0] m;
    m = 8'hA5;
    base = log_n;
    chan_mask = m;
    scan_en = 1'b1;
    guard = 0;
    while (log_n < base + 7 && guard < 5000) begin @(negedge clk); guard++; end
    scan_en = 1'b0;
    repeat (200) @(negedge clk);
    chk(m[log_ch[base]] == 1'b1, "R4 first sparse channel enabled", log_ch[base], 0);
    for (int i = 0; i < 6; i++)
      chk(log_ch[base + i + 1] == next_en(log_ch[base + i], m), "R4 sparse order skips",
          log_ch[base + i + 1], next_en(log_ch[base + i], m));
  endtask

  task automatic t_rd_hold();
    int base;
    int guard;
    base = rd_cnt;
    rd_hold = 4'd5;
    chan_mask = 8'h10;
    scan_en = 1'b1;
    guard = 0;
    while (rd_cnt < base + 2 && guard < 5000) begin @(negedge clk); guard++; end
    scan_en = 1'b0;
    repeat (200) @(negedge clk);
    chk(last_rd_len == 5, "R6 longer read pulse", last_rd_len, 5);
    rd_hold = 4'd0;
    scan_en = 1'b1;
    base = rd_cnt;
    guard = 0;
    while (rd_cnt < base + 1 && guard < 5000) begin @(negedge clk); guard++; end
    scan_en = 1'b0;
    repeat (200) @(negedge clk);
    chk(last_rd_len == 1, "R6 zero hold gives one cycle", last_rd_len, 1);
    rd_hold = 4'd2;
  endtask

  task automatic t_timeout();
    int base;
    int rdb;
    int guard;
    consume(1);
    m_hang = 1'b1;
    base = log_n;
    rdb = rd_cnt;
    chan_mask = 8'h02;
    scan_en = 1'b1;
    guard = 0;
    while (log_n < base + 2 && guard < 3000) begin @(negedge clk); guard++; end
    scan_en = 1'b0;
    chk(timeout_err == 1'b1, "R8 timeout flag", int'(timeout_err), 1);
    chk(log_n >= base + 2, "R8 scan moves on", log_n - base, 2);
    chk(rd_cnt == rdb, "R8 no read after timeout", rd_cnt - rdb, 0);
    res_sel = 3'd1;
    @(negedge clk);
    chk(res_valid == 1'b0, "R8 nothing stored", int'(res_valid), 0);
    repeat (300) @(negedge clk);
    m_hang = 1'b0;
    repeat (100) @(negedge clk);
    chk(timeout_err == 1'b1, "R8 flag stays set", int'(timeout_err), 1);
  endtask

  task automatic t_quiet();
    int base;
    base = log_n;
    chan_mask = 8'h00;
    scan_en = 1'b1;
    repeat (300) @(negedge clk);
    chk(log_n == base, "R10 empty mask no strobe", log_n - base, 0);
    chan_mask = 8'hFF;
    scan_en = 1'b0;
    repeat (300) @(negedge clk);
    chk(log_n == base, "R10 disabled no strobe", log_n - base, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clkdiv(2);
    t_clkdiv(1);
    rd_hold = 4'd2;
    t_scan_full();
    t_consume();
    t_scan_sparse();
    t_rd_hold();
    t_timeout();
    t_quiet();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule